// File: doc/BRIEF.md
# Two-Beat Burst SRAM with Byte-Lane Masks

This block is a synthesizable single-port memory that follows a double-data-rate SRAM command style in which every access moves a fixed burst of two data beats. One rising clock edge captures a command made of an active-low load strobe, a direction bit and a shared address. The two beats are carried on one internal clock as a beat-0/beat-1 pair. They stand for the data on the two complementary clock edges of the external bus. Each beat owns one storage bank, and both banks are indexed by the same address.

Write data is split into 9-bit lanes. Each beat has its own set of active-low lane selects, so a write can update any subset of lanes in either beat. Read data comes back a fixed, parameterizable number of cycles after the command. It is qualified by a valid flag and an output enable. While no read response is present the outputs count as high impedance: the enable is low and the data is forced to zero.

Writes are committed one cycle after capture, which models beat 1 arriving late. A read of the same address in the next cycle picks up the pending write through a lane-wise forwarding mux. Commands are accepted on every cycle without stalls.

Top module: `burst2_sram`

## Requirements
- R1: A command is accepted only when ld_ni is low at a rising clock edge. With ld_ni high the stored contents do not change and no read response is produced, whatever the other inputs carry.
- R2: For an accepted command, rw_i = 1 selects a read and rw_i = 0 selects a write.
- R3: Each command moves a pair of beats at the one address. Beat 0 (wdata0_i / rdata0_o) is stored in bank 0 and beat 1 (wdata1_i / rdata1_o) in bank 1, independently of each other.
- R4: The data bus is split into DATA_W/9 lanes, and lane k occupies bits 9k+8 down to 9k.
- R5: bsel0_ni qualifies beat 0 and bsel1_ni qualifies beat 1. Both are active low. Bit k = 1 leaves lane k of that beat unchanged in storage.
- R6: For a read accepted in cycle n, rvalid_o and oe_o are high exactly during cycle n+RD_LAT (default 2), and during that cycle rdata0_o/rdata1_o carry the addressed pair.
- R7: Whenever rvalid_o is low, oe_o is low and both read data outputs are zero, which models the high-impedance state.
- R8: The asynchronous reset rst_ni clears the read pipeline and any pending write. While in reset and after it, rvalid_o and oe_o are low, and a read in flight when reset is applied produces no response.
- R9: A read in the cycle right after a write to the same address returns the newly written lanes merged with the stored lanes that were masked.
- R10: Commands in consecutive cycles, reads and writes mixed, are all accepted without stalls. Reads produce one response per cycle, in command order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; commands are captured on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_ni | input | 1 | Active-low command load strobe |
| rw_i | input | 1 | Direction: 1 read, 0 write |
| addr_i | input | ADDR_W | Shared read/write pair address |
| wdata0_i | input | DATA_W | Write data, beat 0 |
| wdata1_i | input | DATA_W | Write data, beat 1 |
| bsel0_ni | input | DATA_W/9 | Active-low lane selects for beat 0 |
| bsel1_ni | input | DATA_W/9 | Active-low lane selects for beat 1 |
| rdata0_o | output | DATA_W | Read data, beat 0 (zero when not valid) |
| rdata1_o | output | DATA_W | Read data, beat 1 (zero when not valid) |
| rvalid_o | output | 1 | Read data valid |
| oe_o | output | 1 | Output drive enable; low means high impedance |

## Verification
The assertions check three things on every cycle. A cycle with load high or with a read command never leads to a write commit. A full-lane write followed at once by a read of the same address forwards the written pair. Reset keeps the valid flag and the output enable low. Other behaviours can only be shown by the bench's scenarios: the exact read latency, the lane-to-bit mapping and the per-beat masking seen through read-back, in-order responses to back-to-back reads, and the discarding of a read that a reset cuts off.

// File: rtl/b2_sram_pkg.sv
package b2_sram_pkg;
  localparam int unsigned LANE_W    = 9;
  localparam int unsigned NUM_BEATS = 2;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } op_e;
endpackage

// File: rtl/b2_cmd_stage.sv
module b2_cmd_stage
  import b2_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 36,
  parameter int unsigned LANES  = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_ni,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata0_i,
  input  logic [DATA_W-1:0] wdata1_i,
  input  logic [LANES-1:0]  bsel0_ni,
  input  logic [LANES-1:0]  bsel1_ni,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o [NUM_BEATS],
  output logic [LANES-1:0]  wr_lane_en_o [NUM_BEATS]
);
  op_e  op;
  logic cmd_vld;

  assign cmd_vld = ~ld_ni;
  assign op      = op_e'(rw_i);

  // reads address the banks straight from the pins
  assign rd_en_o   = cmd_vld && (op == OP_READ);
  assign rd_addr_o = addr_i;

  // writes are staged one cycle (late beat-1 arrival)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_en_o <= 1'b0;
    else         wr_en_o <= cmd_vld && (op == OP_WRITE);
  end

  always_ff @(posedge clk_i) begin
    if (cmd_vld && (op == OP_WRITE)) begin
      wr_addr_o       <= addr_i;
      wr_data_o[0]    <= wdata0_i;
      wr_data_o[1]    <= wdata1_i;
      wr_lane_en_o[0] <= ~bsel0_ni;
      wr_lane_en_o[1] <= ~bsel1_ni;
    end
  end
endmodule

// File: rtl/b2_bank.sv
module b2_bank
  import b2_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 36,
  parameter int unsigned LANES  = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [LANES-1:0]  wr_lane_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic hit;
  assign hit = wr_en_i && rd_en_i && (wr_addr_i == rd_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_lane_en_i[l])
        mem[wr_addr_i] <= wr_data_i[l*LANE_W +: LANE_W];
    end

    // lane-wise forward of the pending write
    always_ff @(posedge clk_i) begin
      if (rd_en_i)
        rd_q <= (hit && wr_lane_en_i[l]) ? wr_data_i[l*LANE_W +: LANE_W]
                                         : mem[rd_addr_i];
    end

    assign rd_data_o[l*LANE_W +: LANE_W] = rd_q;
  end

  // R9
  fwd_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && wr_en_i && (rd_addr_i == wr_addr_i) && (&wr_lane_en_i))
      |=> (rd_data_o == $past(wr_data_i)));
endmodule

// File: rtl/b2_rd_pipe.sv
module b2_rd_pipe
  import b2_sram_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned RD_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] bank_data_i [NUM_BEATS],
  output logic [DATA_W-1:0] rdata_o [NUM_BEATS],
  output logic              rvalid_o,
  output logic              oe_o
);
  localparam int unsigned PW = NUM_BEATS * DATA_W;

  logic [RD_LAT-1:0] vld_q;
  logic [PW-1:0]     bank_pair;
  logic [PW-1:0]     out_pair;

  assign bank_pair = {bank_data_i[1], bank_data_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (RD_LAT > 1) vld_q <= {vld_q[RD_LAT-2:0], rd_en_i};
    else vld_q <= rd_en_i;
  end

  if (RD_LAT > 1) begin : g_dly
    logic [PW-1:0] d_q [RD_LAT-1];
    always_ff @(posedge clk_i) begin
      d_q[0] <= bank_pair;
      for (int i = 1; i < RD_LAT - 1; i++) d_q[i] <= d_q[i-1];
    end
    assign out_pair = d_q[RD_LAT-2];
  end else begin : g_direct
    assign out_pair = bank_pair;
  end

  assign rvalid_o   = vld_q[RD_LAT-1];
  assign oe_o       = vld_q[RD_LAT-1];
  assign rdata_o[0] = rvalid_o ? out_pair[DATA_W-1:0]  : '0;
  assign rdata_o[1] = rvalid_o ? out_pair[PW-1:DATA_W] : '0;
endmodule

// File: rtl/burst2_sram.sv
module burst2_sram
  import b2_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 36,
  parameter int unsigned RD_LAT = 2,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_ni,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata0_i,
  input  logic [DATA_W-1:0] wdata1_i,
  input  logic [LANES-1:0]  bsel0_ni,
  input  logic [LANES-1:0]  bsel1_ni,
  output logic [DATA_W-1:0] rdata0_o,
  output logic [DATA_W-1:0] rdata1_o,
  output logic              rvalid_o,
  output logic              oe_o
);
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data [NUM_BEATS];
  logic [LANES-1:0]  wr_lane_en [NUM_BEATS];
  logic [DATA_W-1:0] bank_data [NUM_BEATS];
  logic [DATA_W-1:0] rdata [NUM_BEATS];

  b2_cmd_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_cmd (
    .clk_i, .rst_ni, .ld_ni, .rw_i, .addr_i, .wdata0_i, .wdata1_i,
    .bsel0_ni, .bsel1_ni,
    .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_lane_en_o(wr_lane_en)
  );

  for (genvar b = 0; b < NUM_BEATS; b++) begin : g_bank
    b2_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_bank (
      .clk_i, .rst_ni,
      .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data[b]), .wr_lane_en_i(wr_lane_en[b]),
      .rd_en_i(rd_en), .rd_addr_i(rd_addr),
      .rd_data_o(bank_data[b])
    );
  end

  b2_rd_pipe #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_rd (
    .clk_i, .rst_ni, .rd_en_i(rd_en), .bank_data_i(bank_data),
    .rdata_o(rdata), .rvalid_o, .oe_o
  );

  assign rdata0_o = rdata[0];
  assign rdata1_o = rdata[1];

  // R1
  ld_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ni |=> !wr_en);

  // R2
  rd_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_ni && rw_i) |=> !wr_en);

  // R8
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      rst_quiet_chk: assert (!rvalid_o && !oe_o);
    end
  end
endmodule

// File: tb/sim_burst2_sram.sv
module sim_burst2_sram;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 36;
  localparam int unsigned LAT = 2;
  localparam int unsigned NL = DW / 9;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ld_ni = 1'b1;
  logic          rw_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata0_i = '0, wdata1_i = '0;
  logic [NL-1:0] bsel0_ni = '1, bsel1_ni = '1;
  logic [DW-1:0] rdata0_o, rdata1_o;
  logic          rvalid_o, oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] ref0 [1<<AW];
  logic [DW-1:0] ref1 [1<<AW];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst2_sram #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) u0 (.*);

  task automatic chk(input string req, input logic [2*DW+1:0] act, input logic [2*DW+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic [NL-1:0] m_n);
    logic [DW-1:0] r = old;
    for (int k = 0; k < NL; k++) if (!m_n[k]) r[k*9 +: 9] = nw[k*9 +: 9];
    return r;
  endfunction

  task automatic idle();
    ld_ni = 1'b1; rw_i = 1'b1; wdata0_i = '0; wdata1_i = '0; bsel0_ni = '1; bsel1_ni = '1;
  endtask

  task automatic drive_wr(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                          input logic [NL-1:0] m0, input logic [NL-1:0] m1);
    ld_ni = 1'b0; rw_i = 1'b0; addr_i = a; wdata0_i = d0; wdata1_i = d1; bsel0_ni = m0; bsel1_ni = m1;
    ref0[a] = merge(ref0[a], d0, m0);
    ref1[a] = merge(ref1[a], d1, m1);
  endtask

  task automatic drive_rd(input logic [AW-1:0] a);
    ld_ni = 1'b0; rw_i = 1'b1; addr_i = a; bsel0_ni = '1; bsel1_ni = '1;
  endtask

  task automatic expect_out(input string req, input logic [AW-1:0] a);
    chk(req, {rvalid_o, oe_o, rdata1_o, rdata0_o}, {2'b11, ref1[a], ref0[a]});
  endtask

  task automatic expect_idle(input string req);
    chk(req, {rvalid_o, oe_o, rdata1_o, rdata0_o}, '0);
  endtask

  task automatic write_pair(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                            input logic [NL-1:0] m0, input logic [NL-1:0] m1);
    @(negedge clk_i); drive_wr(a, d0, d1, m0, m1);
    @(negedge clk_i); idle();
  endtask

  task automatic read_check(input string req, input logic [AW-1:0] a);
    @(negedge clk_i); drive_rd(a);
    @(negedge clk_i); idle(); expect_idle({req, " R6 early"});
    @(negedge clk_i); expect_out(req, a);
    @(negedge clk_i); expect_idle({req, " R7 after"});
  endtask

  task automatic t_reset();
    expect_idle("R8 R7 reset state");
  endtask

  task automatic t_full_write_read();
    write_pair(8'h10, 36'h1_2345_6789, 36'hA_BCDE_F012, '0, '0);
    write_pair(8'h11, 36'h5_5555_5555, 36'hA_AAAA_AAAA, '0, '0);
    read_check("R2 R3 R6 full read", 8'h10);
    read_check("R3 R6 second pair", 8'h11);
  endtask

  task automatic t_lane_masks();
    write_pair(8'h20, 36'h0_0000_0000, 36'hF_FFFF_FFFF, '0, '0);
    // beat0 lanes 1,3 written; beat1 only lane 2 written
    write_pair(8'h20, 36'h1_2345_6789, 36'h0_0000_0000, 4'b0101, 4'b1011);
    read_check("R4 R5 per-beat lane masks", 8'h20);
    write_pair(8'h20, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 4'b1111, 4'b1111);
    read_check("R5 all lanes deselected", 8'h20);
  endtask

  task automatic t_ignored();
    @(negedge clk_i); ld_ni = 1'b1; rw_i = 1'b0; addr_i = 8'h10;
    wdata0_i = '1; wdata1_i = '1; bsel0_ni = '0; bsel1_ni = '0;
    @(negedge clk_i); idle(); addr_i = 8'h10;
    @(negedge clk_i); expect_idle("R1 no response to ignored cycle");
    read_check("R1 ld high write ignored", 8'h10);
    @(negedge clk_i); ld_ni = 1'b1; rw_i = 1'b1; addr_i = 8'h11;
    @(negedge clk_i); idle(); expect_idle("R1 ld high read n+1");
    @(negedge clk_i); expect_idle("R1 ld high read n+2");
  endtask

  task automatic t_forward();
    write_pair(8'h30, 36'h3_3333_3333, 36'h4_4444_4444, '0, '0);
    @(negedge clk_i); drive_wr(8'h30, 36'hC_CCCC_CCCC, 36'hD_DDDD_DDDD, 4'b0011, 4'b1100);
    @(negedge clk_i); drive_rd(8'h30);
    @(negedge clk_i); idle(); expect_idle("R9 fwd early");
    @(negedge clk_i); expect_out("R9 forwarded merged pair", 8'h30);
    @(negedge clk_i); drive_wr(8'h31, 36'h7_0000_0007, 36'h8_0000_0008, '0, '0);
    @(negedge clk_i); drive_rd(8'h31);
    @(negedge clk_i); idle();
    @(negedge clk_i); expect_out("R9 forwarded full pair", 8'h31);
  endtask

  task automatic t_back_to_back();
    @(negedge clk_i); drive_rd(8'h10);
    @(negedge clk_i); drive_wr(8'h40, 36'h9_8765_4321, 36'h1_1111_1111, '0, '0);
    @(negedge clk_i); drive_rd(8'h20); expect_out("R10 b2b first", 8'h10);
    @(negedge clk_i); drive_rd(8'h40); expect_idle("R10 write slot has no response");
    @(negedge clk_i); drive_rd(8'h30); expect_out("R10 b2b second", 8'h20);
    @(negedge clk_i); idle(); expect_out("R10 b2b third", 8'h40);
    @(negedge clk_i); expect_out("R10 b2b fourth", 8'h30);
    @(negedge clk_i); expect_idle("R10 stream end");
  endtask

  task automatic t_reset_in_flight();
    @(negedge clk_i); drive_rd(8'h10);
    @(negedge clk_i); idle(); rst_ni = 1'b0;
    #1 expect_idle("R8 outputs low in reset");
    @(negedge clk_i); rst_ni = 1'b1; expect_idle("R8 in-flight read dropped");
    @(negedge clk_i); expect_idle("R8 quiet after reset");
    read_check("R8 read after reset", 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_full_write_read();
    t_lane_masks();
    t_ignored();
    t_forward();
    t_back_to_back();
    t_reset_in_flight();
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule